// File: doc/BRIEF.md
# Multiplexed Video-Memory Bus Sequencer

This block connects the internal fetch and register logic of a tile-based video processor to its external video memory. The memory address is 14 bits wide. Its upper six bits leave on dedicated output pins. Its low byte shares an 8-bit bidirectional bus with the data, so every external access starts with a one-pixel-cycle address phase. In that phase a latch-enable strobe lets an external latch capture the low byte. A data phase follows, with an active-low read or write strobe.

The whole sequencer runs on the fast input clock. An internal divider makes a pixel-clock enable, and all bus activity advances only on that enable. The divide ratio is 4 or 5, selected by a pin. Requests arrive through a valid/ready handshake, and read results come back as a one-clock response pulse.

Addresses in the window 0x3F00..0x3FFF never reach the external bus. They are served by a small internal colour-table store, and no latch or strobe activity appears on the pins. The bidirectional pad itself sits at the chip edge. This block provides its output value, its output enable and its input value as separate ports.

Top module: `vram_bus_seq`

## Requirements
- R1: While and after reset, `ale` is 0, `rd_n` and `wr_n` are 1, `ad_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: `pix_ce` is high for one clock out of every 4 clocks when `div5_sel` is 0, and for one clock out of every 5 clocks when `div5_sel` is 1.
- R3: A request is taken on a clock edge where `pix_ce`, `req_valid` and `req_ready` are all high. For an external access, `ale` is then high for exactly one pixel cycle (4 or 5 clocks). During that cycle `ad_oe` is 1, `ad_o` equals address bits 7..0 and `addr_hi` equals address bits 13..8.
- R4: In the second pixel cycle of an external read, `ale` is 0, `rd_n` is 0, `wr_n` is 1 and `ad_oe` is 0.
- R5: In the second pixel cycle of an external write, `ale` is 0, `wr_n` is 0, `rd_n` is 1, `ad_oe` is 1 and `ad_o` equals the write data.
- R6: For an external read, `ad_i` is sampled at the pixel edge that ends the second cycle. The sampled byte appears on `rsp_rdata` with `rsp_valid` high for one clock, two pixel cycles after acceptance.
- R7: `req_ready` falls right after acceptance. It returns high two pixel cycles later for an external access and one pixel cycle later for a colour-table access.
- R8: A write with address bits 13..8 equal to 0x3F stores its data internally at index address[4:0]. It raises neither `ale` nor `wr_n` low, and it leaves the external memory unchanged.
- R9: A read with address bits 13..8 equal to 0x3F returns the stored byte at index address[4:0] after one pixel cycle, without any `ale` or `rd_n` activity. Reset clears the store to zero.
- R10: `rd_n` and `wr_n` are never low at the same time. `ad_oe` is 0 outside the address phase and the write data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| div5_sel | input | 1 | 1 selects divide-by-5, 0 selects divide-by-4 pixel clock |
| pix_ce | output | 1 | Pixel-clock enable, one clock wide |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, can take a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 14 | Memory address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid, one clock pulse |
| rsp_rdata | output | 8 | Read data |
| ale | output | 1 | Address latch enable |
| addr_hi | output | 6 | Address bits 13..8 |
| ad_o | output | 8 | Shared bus output value |
| ad_oe | output | 1 | Shared bus output enable |
| ad_i | input | 8 | Shared bus input value |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
The properties assume that `div5_sel` changes only while reset is held. They also assume that the divide ratio is at least 4, so a pixel enable or a response pulse is never followed by another on the next clock. They further assume that a requester holds `req_valid` and its fields steady until acceptance. The bench's driver changes the ratio only inside a reset sequence and holds each request at the falling clock edge until the enable and ready are both seen high. Its behavioural latch and RAM take the bus value only while the sequencer drives it.

// File: rtl/vbs_pkg.sv
package vbs_pkg;

    localparam int ADDR_W     = 14;
    localparam int DATA_W     = 8;
    localparam int LO_W       = 8;
    localparam int HI_W       = ADDR_W - LO_W;
    localparam int PAL_DEPTH  = 32;
    localparam int PAL_IDX_W  = $clog2(PAL_DEPTH);
    localparam int DIV_FAST   = 4;
    localparam int DIV_SLOW   = 5;
    localparam int DIV_CNT_W  = $clog2(DIV_SLOW);
    localparam logic [HI_W-1:0] PAL_PAGE = 6'h3F;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_PAL
    } seq_state_t;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } mem_req_t;

    function automatic logic is_palette(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:LO_W] == PAL_PAGE;
    endfunction

endpackage

// File: rtl/vbs_clk_div.sv
module vbs_clk_div
    import vbs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic div5_sel,
    output logic pix_ce
);

    localparam logic [DIV_CNT_W-1:0] LAST_FAST = DIV_CNT_W'(DIV_FAST - 1);
    localparam logic [DIV_CNT_W-1:0] LAST_SLOW = DIV_CNT_W'(DIV_SLOW - 1);

    logic [DIV_CNT_W-1:0] cnt;
    logic [DIV_CNT_W-1:0] last;

    assign last   = div5_sel ? LAST_SLOW : LAST_FAST;
    assign pix_ce = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt >= last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/vbs_palette.sv
module vbs_palette
    import vbs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [PAL_IDX_W-1:0] idx,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata
);

    logic [DATA_W-1:0] store [PAL_DEPTH];

    generate
        for (genvar g = 0; g < PAL_DEPTH; g++) begin : g_entry
            always_ff @(posedge clk) begin
                if (rst) begin
                    store[g] <= '0;
                end else if (we && idx == PAL_IDX_W'(g)) begin
                    store[g] <= wdata;
                end
            end
        end
    endgenerate

    assign rdata = store[idx];

endmodule

// File: rtl/vbs_seq_fsm.sv
module vbs_seq_fsm
    import vbs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pix_ce,
    input  logic                 req_valid,
    input  mem_req_t             req_in,
    output logic                 req_ready,
    output logic                 rsp_valid,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic                 ale,
    output logic [HI_W-1:0]      addr_hi,
    output logic [LO_W-1:0]      ad_o,
    output logic                 ad_oe,
    input  logic [LO_W-1:0]      ad_i,
    output logic                 rd_n,
    output logic                 wr_n,
    output logic                 pal_we,
    output logic [PAL_IDX_W-1:0] pal_idx,
    output logic [DATA_W-1:0]    pal_wdata,
    input  logic [DATA_W-1:0]    pal_rdata
);

    seq_state_t      state;
    mem_req_t        cur;
    logic [HI_W-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cur       <= '0;
            hi_q      <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (pix_ce) begin
                unique case (state)
                    ST_IDLE: begin
                        if (req_valid) begin
                            cur <= req_in;
                            if (is_palette(req_in.addr)) begin
                                state <= ST_PAL;
                            end else begin
                                hi_q  <= req_in.addr[ADDR_W-1:LO_W];
                                state <= ST_ADDR;
                            end
                        end
                    end
                    ST_ADDR: state <= ST_DATA;
                    ST_DATA: begin
                        if (!cur.wr) begin
                            rsp_valid <= 1'b1;
                            rsp_rdata <= ad_i;
                        end
                        state <= ST_IDLE;
                    end
                    ST_PAL: begin
                        if (!cur.wr) begin
                            rsp_valid <= 1'b1;
                            rsp_rdata <= pal_rdata;
                        end
                        state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        req_ready = (state == ST_IDLE);
        ale       = (state == ST_ADDR);
        rd_n      = !(state == ST_DATA && !cur.wr);
        wr_n      = !(state == ST_DATA && cur.wr);
        ad_oe     = (state == ST_ADDR) || (state == ST_DATA && cur.wr);
        ad_o      = (state == ST_ADDR) ? cur.addr[LO_W-1:0] : cur.wdata;
        addr_hi   = hi_q;
        pal_we    = pix_ce && (state == ST_PAL) && cur.wr;
        pal_idx   = cur.addr[PAL_IDX_W-1:0];
        pal_wdata = cur.wdata;
    end

endmodule

// File: rtl/vram_bus_seq.sv
module vram_bus_seq
    import vbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              div5_sel,
    output logic              pix_ce,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              ale,
    output logic [HI_W-1:0]   addr_hi,
    output logic [LO_W-1:0]   ad_o,
    output logic              ad_oe,
    input  logic [LO_W-1:0]   ad_i,
    output logic              rd_n,
    output logic              wr_n
);

    mem_req_t             req_in;
    logic                 pal_we;
    logic [PAL_IDX_W-1:0] pal_idx;
    logic [DATA_W-1:0]    pal_wdata;
    logic [DATA_W-1:0]    pal_rdata;

    assign req_in = '{wr: req_write, addr: req_addr, wdata: req_wdata};

    vbs_clk_div u_div (
        .clk      (clk),
        .rst      (rst),
        .div5_sel (div5_sel),
        .pix_ce   (pix_ce)
    );

    vbs_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .pix_ce    (pix_ce),
        .req_valid (req_valid),
        .req_in    (req_in),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .ale       (ale),
        .addr_hi   (addr_hi),
        .ad_o      (ad_o),
        .ad_oe     (ad_oe),
        .ad_i      (ad_i),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .pal_we    (pal_we),
        .pal_idx   (pal_idx),
        .pal_wdata (pal_wdata),
        .pal_rdata (pal_rdata)
    );

    vbs_palette u_pal (
        .clk   (clk),
        .rst   (rst),
        .we    (pal_we),
        .idx   (pal_idx),
        .wdata (pal_wdata),
        .rdata (pal_rdata)
    );

endmodule

// File: rtl/vbs_checker.sv
module vbs_checker
    import vbs_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            pix_ce,
    input logic            req_valid,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic            ale,
    input logic [HI_W-1:0] addr_hi,
    input logic            ad_oe,
    input logic            rd_n,
    input logic            wr_n
);

    a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    a_r4_released_on_read: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe);

    a_r3_ale_drives_bus: assert property (@(posedge clk) disable iff (rst)
        ale |-> (ad_oe && rd_n && wr_n));

    a_r3_ale_one_pixel: assert property (@(posedge clk) disable iff (rst)
        (ale && pix_ce) |=> !ale);

    a_r7_busy_after_take: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && pix_ce) |=> !req_ready);

    a_r6_rsp_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    a_r2_enable_single: assert property (@(posedge clk) disable iff (rst)
        pix_ce |=> !pix_ce);

    a_r8_no_ext_write_palette: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> (addr_hi != PAL_PAGE));

endmodule

bind vram_bus_seq vbs_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .pix_ce    (pix_ce),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .ale       (ale),
    .addr_hi   (addr_hi),
    .ad_oe     (ad_oe),
    .rd_n      (rd_n),
    .wr_n      (wr_n)
);

// File: tb/test_vram_bus_seq.sv
module test_vram_bus_seq;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst;
    logic        div5_sel;
    logic        pix_ce;
    logic        req_valid;
    logic        req_ready;
    logic        req_write;
    logic [13:0] req_addr;
    logic [7:0]  req_wdata;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic        ale;
    logic [5:0]  addr_hi;
    logic [7:0]  ad_o;
    logic        ad_oe;
    logic [7:0]  ad_i;
    logic        rd_n;
    logic        wr_n;

    int checks = 0;
    int errors = 0;
    int cur_div = 4;
    int cycles = 0;

    logic [7:0]  ram     [1024];
    logic [7:0]  ref_ext [1024];
    logic [7:0]  ref_pal [32];
    logic [7:0]  lat;
    logic [13:0] addr_q  [$];
    logic [7:0]  wdata_q [$];
    logic [7:0]  rdata_q [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    vram_bus_seq i_vram_bus_seq (
        .clk       (clk),
        .rst       (rst),
        .div5_sel  (div5_sel),
        .pix_ce    (pix_ce),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .ale       (ale),
        .addr_hi   (addr_hi),
        .ad_o      (ad_o),
        .ad_oe     (ad_oe),
        .ad_i      (ad_i),
        .rd_n      (rd_n),
        .wr_n      (wr_n)
    );

    // behavioural address latch and memory on the shared bus
    always @(posedge clk) begin
        if (ale && ad_oe) lat <= ad_o;
        if (!wr_n && ad_oe) ram[{addr_hi[1:0], lat}] <= ad_o;
    end

    assign ad_i = ad_oe ? ad_o : (!rd_n ? ram[{addr_hi[1:0], lat}] : 8'hzz);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: compares bus activity and responses against queued expectations
    int  ale_len = 0;
    bit  wr_prev = 1'b1;
    bit  rd_prev = 1'b1;
    always @(negedge clk) begin
        if (!rst) begin
            if (ale) begin
                if (ale_len == 0) begin
                    if (addr_q.size() == 0) check(0, "R3 unexpected ale", 1, 0);
                    else begin
                        logic [13:0] ea;
                        ea = addr_q.pop_front();
                        check({addr_hi, ad_o} == ea && ad_oe, "R3 address phase",
                              {addr_hi, ad_o}, ea);
                    end
                end
                ale_len++;
            end else if (ale_len != 0) begin
                check(ale_len == cur_div, "R3 ale length", ale_len, cur_div);
                ale_len = 0;
            end
            if (!wr_n && wr_prev) begin
                if (wdata_q.size() == 0) check(0, "R5 unexpected wr_n", 1, 0);
                else begin
                    logic [7:0] ew;
                    ew = wdata_q.pop_front();
                    check(ad_o == ew && ad_oe && rd_n && !ale, "R5 write phase", ad_o, ew);
                end
                check(addr_hi != 6'h3F, "R8 external write in colour window", addr_hi, 0);
            end
            if (!rd_n && rd_prev) begin
                check(!ad_oe && wr_n && !ale, "R4 read phase released", ad_oe, 0);
                check(addr_hi != 6'h3F, "R9 external read in colour window", addr_hi, 0);
            end
            if (!rd_n && !wr_n) check(0, "R10 both strobes low", 0, 1);
            if (rsp_valid) begin
                if (rdata_q.size() == 0) check(0, "R6 unexpected rsp", 1, 0);
                else begin
                    logic [7:0] er;
                    er = rdata_q.pop_front();
                    check(rsp_rdata == er, "R6/R9 read data", rsp_rdata, er);
                end
            end
            wr_prev = wr_n;
            rd_prev = rd_n;
        end
    end

    task automatic do_reset(input logic sel);
        @(negedge clk);
        rst       = 1'b1;
        div5_sel  = sel;
        req_valid = 1'b0;
        cur_div   = sel ? 5 : 4;
        repeat (3) @(negedge clk);
        check(!ale && rd_n && wr_n && !ad_oe && !rsp_valid, "R1 outputs in reset", ale, 0);
        rst = 1'b0;
        for (int i = 0; i < 32; i++) ref_pal[i] = 8'h00;
        @(negedge clk);
        check(!ale && rd_n && wr_n && !ad_oe && req_ready && !rsp_valid,
              "R1 outputs after reset", req_ready, 1);
    endtask

    task automatic access(input logic wr, input logic [13:0] a, input logic [7:0] d);
        bit pal;
        int n;
        int exp_n;
        pal = (a[13:8] == 6'h3F);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        while (!(pix_ce && req_ready)) @(negedge clk);
        if (!pal) begin
            addr_q.push_back(a);
            if (wr) begin
                wdata_q.push_back(d);
                ref_ext[{a[9:8], a[7:0]}] = d;
            end else rdata_q.push_back(ref_ext[{a[9:8], a[7:0]}]);
        end else begin
            if (wr) ref_pal[a[4:0]] = d;
            else rdata_q.push_back(ref_pal[a[4:0]]);
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R7 busy after acceptance", req_ready, 0);
        n = 0;
        while (!req_ready) begin
            @(negedge clk);
            n++;
        end
        exp_n = pal ? cur_div : 2 * cur_div;
        check(n == exp_n, "R7 ready return time", n, exp_n);
        if (!wr) check(rsp_valid, "R6/R9 response with ready", rsp_valid, 1);
    endtask

    task automatic measure_div();
        int n;
        while (!pix_ce) @(negedge clk);
        @(negedge clk);
        n = 1;
        while (!pix_ce) begin
            @(negedge clk);
            n++;
        end
        check(n == cur_div, "R2 enable period", n, cur_div);
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst       = 1'b1;
        div5_sel  = 1'b0;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_addr  = '0;
        req_wdata = '0;
        for (int i = 0; i < 1024; i++) begin
            ram[i]     = 8'h00;
            ref_ext[i] = 8'h00;
        end

        for (int pass = 0; pass < 2; pass++) begin
            do_reset(pass[0]);
            measure_div();
            measure_div();
            // R5 writes and R4/R6 reads, external
            access(1'b1, 14'h0305, 8'hA5);
            access(1'b1, 14'h2100, 8'h3C);
            access(1'b1, 14'h01FF, 8'h5A + 8'(pass));
            access(1'b0, 14'h0305, 8'h00);
            access(1'b0, 14'h01FF, 8'h00);
            access(1'b0, 14'h2100, 8'h00);
            // R9 colour store reads zero after reset
            access(1'b0, 14'h3F05, 8'h00);
            // R8 colour write, same low bits as 0x0305, external unchanged
            access(1'b1, 14'h3F05, 8'h77);
            access(1'b0, 14'h3F05, 8'h00);
            access(1'b0, 14'h0305, 8'h00);
            // R8 index taken from address bits 4..0
            access(1'b1, 14'h3FFF, 8'hE1);
            access(1'b0, 14'h3F1F, 8'h00);
            access(1'b0, 14'h3EFF, 8'h00);
            // back-to-back external traffic
            for (int k = 0; k < 6; k++) begin
                access(1'b1, 14'(14'h0040 + k * 14'h0101), 8'(8'h10 * k + 8'h3));
            end
            for (int k = 0; k < 6; k++) begin
                access(1'b0, 14'(14'h0040 + k * 14'h0101), 8'h00);
            end
        end

        repeat (20) @(negedge clk);
        check(addr_q.size() == 0 && wdata_q.size() == 0 && rdata_q.size() == 0,
              "R3/R5/R6 all expected bus events seen",
              addr_q.size() + wdata_q.size() + rdata_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule